// File: doc/BRIEF.md
# Zero-Suppressing Time-Over-Threshold Strip Readout

This block sits behind the discriminators of a multi-channel strip front-end. Every channel delivers a low-threshold and a high-threshold comparator level. The block synchronizes both levels into its clock domain. It samples them once per coarse event tick and compares each sample with the one taken on the previous tick. Every comparator transition is reported together with the event-time count of the tick that saw it. Knowing both the rising and the falling transition of a comparator gives its time over threshold.

Quiet channels are suppressed. A rising low comparator opens an acceptance region around its channel that also covers the two adjacent channels. Activity on those neighbours therefore survives suppression, which keeps the information needed for a cluster centroid. The channels are split into lanes of `MUX_RATIO` channels. Each lane visits its channels in turn, one per fast clock cycle, so one pass over a lane takes exactly one event tick. Accepted transitions are pushed into a per-lane queue that the consumer reads with a show-ahead pop.

Top module: `tot_zs_readout`

## Requirements
- R1: While `rst_n` is low and after it is released, every `rd_valid` bit and every `ovf` bit is 0 and `ev_time` is 0 until the first event tick.
- R2: An event tick occurs every `MUX_RATIO` clock cycles. The first tick falls on the `MUX_RATIO`-th rising edge after reset release. `ev_time` counts ticks, so it reads k after the k-th tick.
- R3: Comparator levels pass through a two-flop synchronizer and are sampled on each tick. A comparator has an edge when its sample differs from the one taken on the previous tick. A record is `{channel[CH_W-1:0], lo_edge, lo_level, hi_edge, hi_level, time[TS_W-1:0]}`, with the channel in the most significant bits. The levels are the new samples, and the time is the `ev_time` value of the sampling tick.
- R4: A low level sampled high on channel c makes channels c-1, c and c+1 eligible on that tick. This holds across lane boundaries. Neighbours outside the array are simply absent.
- R5: A channel that is not eligible produces no record, even when its comparators have edges. A channel with no edge produces no record.
- R6: A channel stays eligible on the tick where the last low level in its neighbourhood falls, so that falling edge is reported. From the following tick on, the channel is no longer eligible unless a low level in its neighbourhood is high again.
- R7: Lane l holds channels l*MUX_RATIO to l*MUX_RATIO+MUX_RATIO-1. Within one tick its records are queued in ascending channel order. The record of lane slot s is written on clock edge s+1 after the sampling tick, so at most one record per channel per tick is produced.
- R8: When a lane queue already holds `FIFO_DEPTH` records, a new record is dropped and that lane's `ovf` bit sets. The bit stays set until `ovf_clr` is seen high on a clock edge; a new drop on the same edge wins over the clear.
- R9: `rd_data` of a lane shows the oldest queued record whenever `rd_valid` is 1. A clock edge with `rd_pop` high removes that record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast scan clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_lo | input | N_CH | Low-threshold comparator level per channel (asynchronous) |
| cmp_hi | input | N_CH | High-threshold comparator level per channel (asynchronous) |
| rd_pop | input | N_CH/MUX_RATIO | Per-lane pop of the oldest record |
| ovf_clr | input | 1 | Clears all overflow flags |
| rd_valid | output | N_CH/MUX_RATIO | Per-lane queue not empty |
| rd_data | output | (N_CH/MUX_RATIO)*(clog2(N_CH)+4+TS_W) | Per-lane oldest record, lane l at bits l*REC_W upward |
| ovf | output | N_CH/MUX_RATIO | Per-lane sticky overflow flag |
| ev_time | output | TS_W | Event-time tick counter |

## Verification
A comparator change needs two edges to cross the synchronizer and is then captured on the next tick. The record for lane slot s appears s+1 edges after that tick, so every record of a tick is queued by the tick that follows. The bench therefore changes inputs on the falling clock edge right after a tick, which always leaves the synchronizer enough time before the next one. It predicts the time stamp as the next tick count and reads the queues on falling edges only after two further ticks. One directed test samples `rd_valid` on the two falling edges just after the sampling tick to pin the slot-0 write to exactly one edge.

// File: rtl/tot_pkg.sv
// Package: shared types of the time-over-threshold readout.
// Assumes: nothing beyond the record layout stated in the brief.
package tot_pkg;

    // Per-channel transition summary carried into a record, MSB first.
    typedef struct packed {
        logic lo_edge;
        logic lo_level;
        logic hi_edge;
        logic hi_level;
    } edge_flags_t;

    localparam int unsigned FLAGS_W = $bits(edge_flags_t);

endpackage

// File: rtl/tot_tick_gen.sv
// Module: tot_tick_gen
// Divides the fast clock into event ticks of MUX_RATIO cycles, provides the
// scan slot index and counts ticks as the event time.
// Assumes: MUX_RATIO >= 2; the event time wraps at 2**TS_W.
module tot_tick_gen #(
    parameter int unsigned MUX_RATIO = 8,
    parameter int unsigned TS_W      = 16,
    localparam int unsigned SLOT_W   = $clog2(MUX_RATIO)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_o,
    output logic              tick_o,
    output logic [TS_W-1:0]   ev_time_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(MUX_RATIO - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [TS_W-1:0]   ev_time_q;

    // Tick fires on the edge that closes the last slot.
    assign tick_o    = (slot_q == LAST_SLOT);
    assign slot_o    = slot_q;
    assign ev_time_o = ev_time_q;

    // Slot counter: walks 0..MUX_RATIO-1 and wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (tick_o) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // Event-time counter: one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_time_q <= '0;
        end else if (tick_o) begin
            ev_time_q <= ev_time_q + 1'b1;
        end
    end

    // R2: the slot restarts after every tick.
    p_tick_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (slot_q == '0));

    // R2: the event time advances by exactly one per tick.
    p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (ev_time_q == $past(ev_time_q) + 1'b1));

    // R2: the event time is frozen between ticks.
    p_time_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> $stable(ev_time_q));

endmodule

// File: rtl/tot_front_sample.sv
// Module: tot_front_sample
// Synchronizes both comparator levels of every channel, samples them on
// each event tick, derives per-comparator edges against the previous
// sample and computes which channels lie in an open enable region.
// Assumes: comparator levels are asynchronous and stay stable for at
// least a few fast cycles; neighbourhood radius is one channel.
module tot_front_sample #(
    parameter int unsigned N_CH = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [N_CH-1:0] cmp_lo_i,
    input  logic [N_CH-1:0] cmp_hi_i,
    output logic [N_CH-1:0] lo_edge_o,
    output logic [N_CH-1:0] lo_level_o,
    output logic [N_CH-1:0] hi_edge_o,
    output logic [N_CH-1:0] hi_level_o,
    output logic [N_CH-1:0] eligible_o
);

    logic [N_CH-1:0] lo_s1, lo_s2, hi_s1, hi_s2;
    logic [N_CH-1:0] lo_snap, hi_snap, lo_prev, hi_prev;
    logic [N_CH-1:0] lo_active;
    logic [N_CH+1:0] act_pad;

    // Two-flop synchronizer for every comparator level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_s1 <= '0;
            lo_s2 <= '0;
            hi_s1 <= '0;
            hi_s2 <= '0;
        end else begin
            lo_s1 <= cmp_lo_i;
            lo_s2 <= lo_s1;
            hi_s1 <= cmp_hi_i;
            hi_s2 <= hi_s1;
        end
    end

    // Tick sampling: keep this tick's sample and the one before it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_snap <= '0;
            hi_snap <= '0;
            lo_prev <= '0;
            hi_prev <= '0;
        end else if (tick_i) begin
            lo_snap <= lo_s2;
            hi_snap <= hi_s2;
            lo_prev <= lo_snap;
            hi_prev <= hi_snap;
        end
    end

    // Edges and new levels, valid for the whole scan window of a tick.
    assign lo_edge_o  = lo_snap ^ lo_prev;
    assign hi_edge_o  = hi_snap ^ hi_prev;
    assign lo_level_o = lo_snap;
    assign hi_level_o = hi_snap;

    // A low level high now, or high on the previous tick, keeps a region open.
    assign lo_active = lo_snap | lo_prev;
    assign act_pad   = {1'b0, lo_active, 1'b0};

    // Region spread to the nearest neighbour on each side.
    for (genvar c = 0; c < N_CH; c++) begin : g_region
        assign eligible_o[c] = act_pad[c] | act_pad[c+1] | act_pad[c+2];

        // R4: a low level captured on a tick makes its own channel eligible.
        p_open_self_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_i && lo_s2[c]) |=> eligible_o[c]);

        if (c > 0) begin : g_left
            // R4: the lower neighbour is opened too.
            p_open_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_i && lo_s2[c]) |=> eligible_o[c-1]);
        end
        if (c < N_CH - 1) begin : g_right
            // R4: the upper neighbour is opened too.
            p_open_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_i && lo_s2[c]) |=> eligible_o[c+1]);
        end
    end

    // R3: the previous sample is the one taken on the tick before.
    p_sample_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (lo_prev == $past(lo_snap)) && (hi_prev == $past(hi_snap)));

    // R3: samples only move on a tick.
    p_sample_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(lo_snap) && $stable(hi_snap));

endmodule

// File: rtl/tot_fifo.sv
// Module: tot_fifo
// Show-ahead record queue with drop-on-full and a sticky overflow flag.
// Assumes: a push that meets a full queue is dropped even if a pop occurs
// on the same edge.
module tot_fifo #(
    parameter int unsigned W     = 25,
    parameter int unsigned DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    input  logic         clr_i,
    output logic         valid_o,
    output logic [W-1:0] rdata_o,
    output logic         ovf_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt;
    logic             full, empty, do_push, do_pop, ovf_q;

    assign full    = (cnt == FULL_CNT);
    assign empty   = (cnt == '0);
    assign do_push = push_i & ~full;
    assign do_pop  = pop_i & ~empty;
    assign valid_o = ~empty;
    assign rdata_o = mem[rptr];
    assign ovf_o   = ovf_q;

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= wdata_i;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Sticky overflow: a drop sets it, a clear resets it, a drop wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (push_i && full) begin
            ovf_q <= 1'b1;
        end else if (clr_i) begin
            ovf_q <= 1'b0;
        end
    end

    // R8: occupancy never exceeds the depth.
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);

    // R8: a push into a full queue leaves it full and flags overflow.
    p_drop_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && !pop_i) |=> (full && ovf_q));

    // R8: the flag holds until a clear.
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_i) |=> ovf_q);

    // R9: a pop without a push removes one record.
    p_pop_advances_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty && !push_i) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/tot_lane.sv
// Module: tot_lane
// One MUX_RATIO:1 scan lane: visits one channel of its group per fast
// cycle, builds a record for an eligible channel with an edge and pushes
// it into the lane queue.
// Assumes: the slot index and event time come from the shared tick
// generator; lane inputs are the lane's slices of the sampled vectors.
module tot_lane
    import tot_pkg::*;
#(
    parameter int unsigned LANE_IDX   = 0,
    parameter int unsigned N_CH       = 128,
    parameter int unsigned MUX_RATIO  = 8,
    parameter int unsigned TS_W       = 16,
    parameter int unsigned FIFO_DEPTH = 16,
    localparam int unsigned SLOT_W    = $clog2(MUX_RATIO),
    localparam int unsigned CH_W      = $clog2(N_CH),
    localparam int unsigned REC_W     = CH_W + FLAGS_W + TS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SLOT_W-1:0]    slot_i,
    input  logic [TS_W-1:0]      ev_time_i,
    input  logic [MUX_RATIO-1:0] lo_edge_i,
    input  logic [MUX_RATIO-1:0] lo_level_i,
    input  logic [MUX_RATIO-1:0] hi_edge_i,
    input  logic [MUX_RATIO-1:0] hi_level_i,
    input  logic [MUX_RATIO-1:0] eligible_i,
    input  logic                 pop_i,
    input  logic                 clr_i,
    output logic                 valid_o,
    output logic [REC_W-1:0]     rdata_o,
    output logic                 ovf_o
);

    localparam logic [CH_W-1:0] BASE_CH = CH_W'(LANE_IDX * MUX_RATIO);

    edge_flags_t      flags;
    logic [CH_W-1:0]  chan;
    logic             wr_en;
    logic [REC_W-1:0] rec;

    // Multiplexer: pick the slot's channel and assemble its record.
    always_comb begin
        flags.lo_edge  = lo_edge_i[slot_i];
        flags.lo_level = lo_level_i[slot_i];
        flags.hi_edge  = hi_edge_i[slot_i];
        flags.hi_level = hi_level_i[slot_i];
        chan  = BASE_CH + CH_W'(slot_i);
        wr_en = eligible_i[slot_i] & (flags.lo_edge | flags.hi_edge);
        rec   = {chan, flags, ev_time_i};
    end

    tot_fifo #(
        .W     (REC_W),
        .DEPTH (FIFO_DEPTH)
    ) queue_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (wr_en),
        .wdata_i (rec),
        .pop_i   (pop_i),
        .clr_i   (clr_i),
        .valid_o (valid_o),
        .rdata_o (rdata_o),
        .ovf_o   (ovf_o)
    );

    // R9: with no pop, the head record stays put.
    p_head_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !pop_i) |=> (valid_o && $stable(rdata_o)));

endmodule

// File: rtl/tot_zs_readout.sv
// Module: tot_zs_readout (top)
// Zero-suppressing time-over-threshold readout: a shared tick generator,
// a front sampler for all channels and one scan lane per MUX_RATIO
// channels, each with its own record queue.
// Assumes: N_CH is a multiple of MUX_RATIO and MUX_RATIO is a power of two.
module tot_zs_readout #(
    parameter int unsigned N_CH       = 128,
    parameter int unsigned MUX_RATIO  = 8,
    parameter int unsigned TS_W       = 16,
    parameter int unsigned FIFO_DEPTH = 16
) (
    input  logic                                                   clk,
    input  logic                                                   rst_n,
    input  logic [N_CH-1:0]                                        cmp_lo,
    input  logic [N_CH-1:0]                                        cmp_hi,
    input  logic [N_CH/MUX_RATIO-1:0]                              rd_pop,
    input  logic                                                   ovf_clr,
    output logic [N_CH/MUX_RATIO-1:0]                              rd_valid,
    output logic [(N_CH/MUX_RATIO)*($clog2(N_CH)+4+TS_W)-1:0]      rd_data,
    output logic [N_CH/MUX_RATIO-1:0]                              ovf,
    output logic [TS_W-1:0]                                        ev_time
);

    localparam int unsigned N_LANE = N_CH / MUX_RATIO;
    localparam int unsigned SLOT_W = $clog2(MUX_RATIO);
    localparam int unsigned REC_W  = $clog2(N_CH) + tot_pkg::FLAGS_W + TS_W;

    logic [SLOT_W-1:0] slot;
    logic              tick;
    logic [N_CH-1:0]   lo_edge, lo_level, hi_edge, hi_level, eligible;

    tot_tick_gen #(
        .MUX_RATIO (MUX_RATIO),
        .TS_W      (TS_W)
    ) tick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_o    (slot),
        .tick_o    (tick),
        .ev_time_o (ev_time)
    );

    tot_front_sample #(
        .N_CH (N_CH)
    ) front_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .cmp_lo_i   (cmp_lo),
        .cmp_hi_i   (cmp_hi),
        .lo_edge_o  (lo_edge),
        .lo_level_o (lo_level),
        .hi_edge_o  (hi_edge),
        .hi_level_o (hi_level),
        .eligible_o (eligible)
    );

    // One scan lane per channel group.
    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
        tot_lane #(
            .LANE_IDX   (l),
            .N_CH       (N_CH),
            .MUX_RATIO  (MUX_RATIO),
            .TS_W       (TS_W),
            .FIFO_DEPTH (FIFO_DEPTH)
        ) lane_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .slot_i     (slot),
            .ev_time_i  (ev_time),
            .lo_edge_i  (lo_edge[l*MUX_RATIO +: MUX_RATIO]),
            .lo_level_i (lo_level[l*MUX_RATIO +: MUX_RATIO]),
            .hi_edge_i  (hi_edge[l*MUX_RATIO +: MUX_RATIO]),
            .hi_level_i (hi_level[l*MUX_RATIO +: MUX_RATIO]),
            .eligible_i (eligible[l*MUX_RATIO +: MUX_RATIO]),
            .pop_i      (rd_pop[l]),
            .clr_i      (ovf_clr),
            .valid_o    (rd_valid[l]),
            .rdata_o    (rd_data[l*REC_W +: REC_W]),
            .ovf_o      (ovf[l])
        );
    end

    // R1: the event time leaves zero only through a tick.
    p_time_from_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_time == '0 && !tick) |=> (ev_time == '0));

endmodule

// File: tb/tot_zs_readout_tb_top.sv
// Bench for tot_zs_readout: a vector table walked by one loop, then
// directed tests for reset, slot timing and overflow.
module tot_zs_readout_tb_top;

    localparam int unsigned N_CH   = 24;
    localparam int unsigned MUX    = 8;
    localparam int unsigned TS_W   = 16;
    localparam int unsigned DEPTH  = 8;
    localparam int unsigned N_LANE = N_CH / MUX;
    localparam int unsigned CH_W   = $clog2(N_CH);
    localparam int unsigned REC_W  = CH_W + 4 + TS_W;

    typedef struct packed {
        logic [N_CH-1:0] lo;
        logic [N_CH-1:0] hi;
        logic [7:0]      n_exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{24'h000020, 24'h000000, 8'd1},  // R4: lo rise ch5
        '{24'h000020, 24'h000060, 8'd2},  // R4: hi on ch5 and neighbour ch6
        '{24'h000000, 24'h000000, 8'd2},  // R6: falls reported on closing tick
        '{24'h000000, 24'h000020, 8'd0},  // R6: region closed, hi dropped
        '{24'h000000, 24'h000000, 8'd0},  // R5: hi fall outside region
        '{24'h000180, 24'h000000, 8'd2},  // R7: ch7/ch8 straddle lanes
        '{24'h000180, 24'h000240, 8'd2},  // R4: neighbours across lanes
        '{24'h000000, 24'h000000, 8'd4},  // R6: all falls
        '{24'h800001, 24'h000002, 8'd3},  // R4: array ends
        '{24'h000000, 24'h000000, 8'd3},  // R6
        '{24'h000000, 24'h001000, 8'd0},  // R5: isolated hi ignored
        '{24'h000000, 24'h000000, 8'd0}   // R5
    };

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [N_CH-1:0]          cmp_lo = '0;
    logic [N_CH-1:0]          cmp_hi = '0;
    logic [N_LANE-1:0]        rd_pop = '0;
    logic                     ovf_clr = 1'b0;
    logic [N_LANE-1:0]        rd_valid;
    logic [N_LANE*REC_W-1:0]  rd_data;
    logic [N_LANE-1:0]        ovf;
    logic [TS_W-1:0]          ev_time;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_cnt = 0;
    bit done = 1'b0;

    logic [N_CH-1:0] m_prev_l = '0, m_prev_h = '0, m_cur_l = '0, m_cur_h = '0;

    tot_zs_readout #(
        .N_CH       (N_CH),
        .MUX_RATIO  (MUX),
        .TS_W       (TS_W),
        .FIFO_DEPTH (DEPTH)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_lo   (cmp_lo),
        .cmp_hi   (cmp_hi),
        .rd_pop   (rd_pop),
        .ovf_clr  (ovf_clr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .ovf      (ovf),
        .ev_time  (ev_time)
    );

    always #10 clk = ~clk;

    // Own tick reference: a tick lands on every MUX-th edge after reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0;
            tick_cnt = 0;
        end else begin
            cyc++;
            if (cyc % MUX == 0) tick_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_tick();
        do begin
            @(posedge clk);
            #1;
        end while (cyc % MUX != 0);
    endtask

    function automatic bit eligible_f(int c);
        bit r = 1'b0;
        for (int d = -1; d <= 1; d++) begin
            int n = c + d;
            if (n >= 0 && n < int'(N_CH)) r |= m_cur_l[n] | m_prev_l[n];
        end
        return r;
    endfunction

    // Reads every lane and compares with the model records (R3, R5, R7, R9).
    task automatic drain(input int ts, output int n);
        n = 0;
        for (int l = 0; l < int'(N_LANE); l++) begin
            for (int s = 0; s < int'(MUX); s++) begin
                int c = l * MUX + s;
                logic le, he;
                logic [REC_W-1:0] exp;
                le = m_cur_l[c] ^ m_prev_l[c];
                he = m_cur_h[c] ^ m_prev_h[c];
                if (eligible_f(c) && (le || he)) begin
                    exp = {CH_W'(c), le, m_cur_l[c], he, m_cur_h[c], TS_W'(ts)};
                    chk(rd_valid[l] == 1'b1, "R9", "record present", 64'(rd_valid[l]), 64'd1);
                    chk(rd_data[l*REC_W +: REC_W] == exp, "R3", "record content (R7 order)",
                        64'(rd_data[l*REC_W +: REC_W]), 64'(exp));
                    rd_pop[l] = 1'b1;
                    @(negedge clk);
                    rd_pop[l] = 1'b0;
                    n++;
                end
            end
            chk(rd_valid[l] == 1'b0, "R5", "no extra record", 64'(rd_valid[l]), 64'd0);
        end
    endtask

    task automatic apply(input logic [N_CH-1:0] lo, input logic [N_CH-1:0] hi,
                         input int n_exp);
        int ts, n;
        wait_tick();
        @(negedge clk);
        m_prev_l = m_cur_l;
        m_prev_h = m_cur_h;
        m_cur_l  = lo;
        m_cur_h  = hi;
        cmp_lo   = lo;
        cmp_hi   = hi;
        ts = tick_cnt + 1;
        wait_tick();
        wait_tick();
        @(negedge clk);
        drain(ts, n);
        chk(n == n_exp, "R7", "records per tick", 64'(n), 64'(n_exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL R7 watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int ts1, n;
        // R1: reset state
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(rd_valid == '0, "R1", "valid in reset", 64'(rd_valid), 64'd0);
        chk(ovf == '0, "R1", "ovf in reset", 64'(ovf), 64'd0);
        chk(ev_time == '0, "R1", "time in reset", 64'(ev_time), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ev_time == '0, "R1", "time before first tick", 64'(ev_time), 64'd0);

        // R2: tick period and count
        wait_tick();
        @(negedge clk);
        chk(ev_time == TS_W'(tick_cnt), "R2", "time after first tick", 64'(ev_time), 64'(tick_cnt));
        wait_tick();
        @(negedge clk);
        chk(ev_time == 16'd2, "R2", "time after second tick", 64'(ev_time), 64'd2);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].lo, VECS[i].hi, int'(VECS[i].n_exp));
        end

        // R7: slot 0 record appears one edge after the sampling tick
        wait_tick();
        @(negedge clk);
        m_prev_l = m_cur_l;
        m_prev_h = m_cur_h;
        m_cur_l  = 24'h000001;
        cmp_lo   = 24'h000001;
        ts1 = tick_cnt + 1;
        wait_tick();
        @(negedge clk);
        chk(rd_valid[0] == 1'b0, "R7", "slot0 not yet written", 64'(rd_valid[0]), 64'd0);
        @(negedge clk);
        chk(rd_valid[0] == 1'b1, "R7", "slot0 written", 64'(rd_valid[0]), 64'd1);
        wait_tick();
        @(negedge clk);
        drain(ts1, n);
        chk(n == 1, "R7", "slot0 record count", 64'(n), 64'd1);
        apply('0, '0, 1);

        // R8: overflow of lane 0
        wait_tick();
        @(negedge clk);
        cmp_lo = 24'h0000FF;
        ts1 = tick_cnt + 1;
        wait_tick();
        wait_tick();
        @(negedge clk);
        cmp_lo = '0;
        wait_tick();
        wait_tick();
        @(negedge clk);
        chk(ovf[0] == 1'b1, "R8", "lane0 overflow", 64'(ovf[0]), 64'd1);
        chk(ovf[1] == 1'b0, "R8", "lane1 no overflow", 64'(ovf[1]), 64'd0);
        m_prev_l = '0;
        m_prev_h = '0;
        m_cur_l  = 24'h0000FF;
        m_cur_h  = '0;
        drain(ts1, n);
        chk(n == int'(DEPTH), "R8", "kept records", 64'(n), 64'(DEPTH));
        chk(ovf[0] == 1'b1, "R8", "flag sticky after drain", 64'(ovf[0]), 64'd1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk(ovf == '0, "R8", "flag cleared", 64'(ovf), 64'd0);
        m_cur_l = '0;

        finish_run();
    end

endmodule